// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a synchronous single-port memory whose read and write operations can follow each other in any order on consecutive clocks, with no idle cycle between them. Address and control are registered on the rising clock edge. Read data appears combinationally in the cycle that follows the edge that registered the read address, so reads are flow-through. Write data is supplied one enabled cycle after its address. It is then held in a one-entry pending-write register, and is committed to the array on the next enabled edge. While a write waits in that register, a read of the same address is served from it, lane by lane.

A sequencer built from three enumerated states drives the block: `OP_IDLE` (deselected), `OP_READ` and `OP_WRITE`. On each enabled edge it takes one of four named transitions. LOAD_READ, LOAD_WRITE and LOAD_DESELECT happen when `adv_n` is low, and the choice among them depends on the chip enables and `we`. CONTINUE happens when `adv_n` is high: the state is kept and a 2-bit burst counter advances through four beats. A fifth transition, STALL, is taken whenever `clk_en` is low: every register, the burst position, the pending write and the output data are frozen. Three chip enables qualify each load. `oe` gates the output-valid flag asynchronously. The bus is modelled as separate `wdata`, `rdata` and `rvalid` ports. The word is two 9-bit byte lanes, and the depth is a parameter.

Top module: `nwsram_flow`

## Requirements
- R1: While `rst_n` is low, and after its release until a read is loaded, `rvalid` is 0. A CONTINUE taken straight after reset leaves the block deselected.
- R2: A read loaded at an enabled edge (`adv_n`=0, all enables 1, `we`=0) drives the stored word on `rdata` with `rvalid`=1 during the cycle that follows that same edge.
- R3: A write loaded at an enabled edge takes `wdata` at the next enabled edge. `byte_en[0]` enables bits 8:0 and `byte_en[1]` enables bits 17:9. A lane whose enable is 0 keeps its old contents.
- R4: Reads and writes alternate on consecutive cycles with no wait state. A read issued in the data cycle of a write to the same address returns the new data in each enabled lane and the old data in each other lane.
- R5: With `clk_en`=0 the sequencer state, the burst position, the pending write and `rdata`/`rvalid` are held, and `wdata` is not taken.
- R6: A load with any of `ce_a`, `ce_b`, `ce_c` at 0 is a deselect. `rvalid` goes to 0, and a write requested in that cycle changes no memory word.
- R7: `oe`=0 forces `rvalid` to 0 within the same cycle, with no clock edge. Restoring `oe`=1 brings the held read data back.
- R8: During the data cycle of a write, `rvalid` is 0 even with `oe`=1.
- R9: With `burst_ilv`=0, successive CONTINUE beats address the base with its two low bits replaced by (base+n) mod 4. After four beats the sequence wraps to the base.
- R10: With `burst_ilv`=1, beat n addresses the base with its two low bits XORed with n.
- R11: CONTINUE while deselected keeps the block deselected with `rvalid`=0.
- R12: A write burst takes one data word per enabled cycle and places the words at the burst addresses in beat order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | 1 = advance, 0 = freeze all state |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c | input | 1 | Chip enable, active high |
| adv_n | input | 1 | 0 = load new address and operation, 1 = continue burst |
| we | input | 1 | 1 = write, 0 = read (sampled on load) |
| byte_en | input | LANES (2) | Per-lane write enable |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW (8) | Word address |
| wdata | input | WORD_W (18) | Write data, one cycle after its address |
| oe | input | 1 | Asynchronous output enable, active high |
| rdata | output | WORD_W (18) | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The assertions check the following on every cycle: the freeze under `clk_en`=0, the step of the burst counter, a deselected load leading to `OP_IDLE` and staying there under CONTINUE, the capture into the pending-write register, and a write's data cycle keeping `rvalid` low. Some properties cannot be seen from one cycle's control signals alone. These are shown only by the bench scenarios: the data values that come back, the per-lane merge between pending data and the array, the linear and interleaved beat orders with their wrap, the loss of `wdata` during a stall, and the asynchronous effect of `oe`.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_state_e;
endpackage

// File: rtl/nwsram_mem.sv
module nwsram_mem #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              wr_go,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    // One storage array per byte lane, each written only when its lane is enabled.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_go && wr_lanes[l]) begin
                cells[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
            end
        end
        assign rd_word[l*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/nwsram_seq.sv
module nwsram_seq
    import nwsram_pkg::*;
#(
    parameter int AW        = 8,
    parameter int LANES     = 2,
    parameter int BURST_LEN = 4,
    localparam int CW       = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             sel,
    input  logic             adv_n,
    input  logic             we,
    input  logic [LANES-1:0] byte_en,
    input  logic             burst_ilv,
    input  logic [AW-1:0]    addr,
    output op_state_e        st,
    output logic [AW-1:0]    cur_addr,
    output logic [LANES-1:0] lanes_q
);
    op_state_e        st_n;
    logic [AW-1:0]    base_q, base_n;
    logic [CW-1:0]    cnt_q, cnt_n;
    logic [LANES-1:0] lanes_n;
    logic [CW-1:0]    beat_lo;

    // Next-state logic: LOAD_READ / LOAD_WRITE / LOAD_DESELECT / CONTINUE
    always_comb begin
        st_n    = st;
        base_n  = base_q;
        cnt_n   = cnt_q;
        lanes_n = lanes_q;
        if (!adv_n) begin
            base_n  = addr;
            cnt_n   = '0;
            lanes_n = byte_en;
            if (sel) st_n = we ? OP_WRITE : OP_READ;
            else     st_n = OP_IDLE;
        end else begin
            unique case (st)
                OP_IDLE: ;
                OP_READ, OP_WRITE: begin
                    cnt_n   = cnt_q + CW'(1);
                    lanes_n = byte_en;
                end
                default: ;
            endcase
        end
    end

    // State register; STALL when clk_en is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= OP_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            lanes_q <= '0;
        end else if (clk_en) begin
            st      <= st_n;
            base_q  <= base_n;
            cnt_q   <= cnt_n;
            lanes_q <= lanes_n;
        end
    end

    // Output process: beat address in the chosen order.
    always_comb begin
        beat_lo  = burst_ilv ? (base_q[CW-1:0] ^ cnt_q) : (base_q[CW-1:0] + cnt_q);
        cur_addr = {base_q[AW-1:CW], beat_lo};
    end

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(st) && $stable(base_q) && $stable(cnt_q));
    p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_n && !sel) |=> st == OP_IDLE);
    p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_n && st != OP_IDLE) |=> cnt_q == CW'($past(cnt_q) + 1'b1));
    p_idle_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_n && st == OP_IDLE) |=> st == OP_IDLE);
endmodule

// File: rtl/nwsram_wreg.sv
module nwsram_wreg #(
    parameter int AW     = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              data_cyc,
    input  logic [AW-1:0]     cur_addr,
    input  logic [LANES-1:0]  lanes_q,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] arr_word,
    output logic [WORD_W-1:0] merged,
    output logic              cm_go,
    output logic [AW-1:0]     cm_addr,
    output logic [LANES-1:0]  cm_lanes,
    output logic [WORD_W-1:0] cm_word
);
    logic pend_v;
    logic hit;

    // Pending entry: taken in a write's data cycle, committed at the next enabled edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            cm_addr  <= '0;
            cm_lanes <= '0;
            cm_word  <= '0;
        end else if (clk_en) begin
            pend_v <= data_cyc;
            if (data_cyc) begin
                cm_addr  <= cur_addr;
                cm_lanes <= lanes_q;
                cm_word  <= wdata;
            end
        end
    end

    assign cm_go = clk_en && pend_v;
    assign hit   = pend_v && (cm_addr == cur_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign merged[l*LANE_W +: LANE_W] = (hit && cm_lanes[l]) ?
            cm_word[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && data_cyc) |=> pend_v && cm_addr == $past(cur_addr));
    p_no_stray_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !data_cyc) |=> !pend_v);
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(pend_v) && $stable(cm_word));
endmodule

// File: rtl/nwsram_flow.sv
module nwsram_flow
    import nwsram_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int LANES     = 2,
    parameter int LANE_W    = 9,
    parameter int BURST_LEN = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int WORD_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              ce_c,
    input  logic              adv_n,
    input  logic              we,
    input  logic [LANES-1:0]  byte_en,
    input  logic              burst_ilv,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              oe,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    op_state_e         st;
    logic [AW-1:0]     cur_addr;
    logic [LANES-1:0]  lanes_q;
    logic [WORD_W-1:0] arr_word, merged, cm_word;
    logic              cm_go;
    logic [AW-1:0]     cm_addr;
    logic [LANES-1:0]  cm_lanes;
    logic              sel;

    assign sel = ce_a && ce_b && ce_c;

    nwsram_seq #(.AW(AW), .LANES(LANES), .BURST_LEN(BURST_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel), .adv_n(adv_n),
        .we(we), .byte_en(byte_en), .burst_ilv(burst_ilv), .addr(addr),
        .st(st), .cur_addr(cur_addr), .lanes_q(lanes_q)
    );

    nwsram_wreg #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wreg (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .data_cyc(st == OP_WRITE),
        .cur_addr(cur_addr), .lanes_q(lanes_q), .wdata(wdata), .arr_word(arr_word),
        .merged(merged), .cm_go(cm_go), .cm_addr(cm_addr), .cm_lanes(cm_lanes),
        .cm_word(cm_word)
    );

    nwsram_mem #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .wr_go(cm_go), .wr_addr(cm_addr), .wr_lanes(cm_lanes),
        .wr_word(cm_word), .rd_addr(cur_addr), .rd_word(arr_word)
    );

    assign rvalid = oe && (st == OP_READ);
    assign rdata  = rvalid ? merged : '0;

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_n && sel && we) |=> !rvalid);
endmodule

// File: tb/tb_nwsram_flow.sv
module tb_nwsram_flow;
    localparam logic [1:0] V_DES = 2'd0, V_RD = 2'd1, V_WR = 2'd2, V_CONT = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  a;
        logic [1:0]  be;
        logic [17:0] wd;
        logic        ev;
        logic [17:0] ed;
    } vec_t;

    // Rows cover R2, R3, R4, R8: wd is data for the previous row's write.
    localparam vec_t TBL [14] = '{
        '{V_WR,  8'h10, 2'b11, 18'h00000, 1'b0, 18'h00000},
        '{V_WR,  8'h11, 2'b11, 18'h12345, 1'b0, 18'h00000},
        '{V_RD,  8'h10, 2'b11, 18'h0ABCD, 1'b1, 18'h12345},
        '{V_RD,  8'h11, 2'b11, 18'h00000, 1'b1, 18'h0ABCD},
        '{V_WR,  8'h20, 2'b11, 18'h00000, 1'b0, 18'h00000},
        '{V_RD,  8'h20, 2'b11, 18'h3F00F, 1'b1, 18'h3F00F},
        '{V_WR,  8'h20, 2'b01, 18'h00000, 1'b0, 18'h00000},
        '{V_RD,  8'h20, 2'b11, 18'h00155, 1'b1, 18'h3F155},
        '{V_RD,  8'h20, 2'b11, 18'h00000, 1'b1, 18'h3F155},
        '{V_WR,  8'h21, 2'b11, 18'h00000, 1'b0, 18'h00000},
        '{V_WR,  8'h22, 2'b11, 18'h00A21, 1'b0, 18'h00000},
        '{V_RD,  8'h21, 2'b11, 18'h00A22, 1'b1, 18'h00A21},
        '{V_RD,  8'h22, 2'b11, 18'h00000, 1'b1, 18'h00A22},
        '{V_DES, 8'h00, 2'b11, 18'h00000, 1'b0, 18'h00000}
    };

    localparam logic [17:0] D0 = 18'h2A000, D1 = 18'h2A111, D2 = 18'h2A222, D3 = 18'h2A333;

    logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1;
    logic ce_a = 1'b0, ce_b = 1'b0, ce_c = 1'b0, adv_n = 1'b0, we = 1'b0;
    logic [1:0] byte_en = 2'b00;
    logic burst_ilv = 1'b0, oe = 1'b1;
    logic [7:0] addr = '0;
    logic [17:0] wdata = '0, rdata;
    logic rvalid;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nwsram_flow dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
        .adv_n(adv_n), .we(we), .byte_en(byte_en), .burst_ilv(burst_ilv), .addr(addr),
        .wdata(wdata), .oe(oe), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [1:0] be,
                         input logic [17:0] wd);
        clk_en  = 1'b1;
        adv_n   = (op == V_CONT);
        {ce_a, ce_b, ce_c} = (op == V_DES) ? 3'b000 : 3'b111;
        we      = (op == V_WR);
        addr    = a;
        byte_en = be;
        wdata   = wd;
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic ev, input logic [17:0] ed);
        checks++;
        if (rvalid !== ev || (ev && rdata !== ed)) begin
            errors++;
            $display("FAIL %s: actual rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 1'b0, '0);
        rst_n = 1'b1;
        apply(V_CONT, 8'h00, 2'b00, '0);
        cycle(); check("R1 continue after reset", 1'b0, '0);
        cycle(); check("R1 R11 still idle", 1'b0, '0);

        for (int i = 0; i < 14; i++) begin
            apply(TBL[i].op, TBL[i].a, TBL[i].be, TBL[i].wd);
            cycle();
            check($sformatf("table row %0d (R2 R3 R4 R8)", i), TBL[i].ev, TBL[i].ed);
        end

        // R12 write burst, linear from 0x42: 42,43,40,41
        apply(V_WR, 8'h42, 2'b11, '0);   cycle(); check("R8 burst addr", 1'b0, '0);
        apply(V_CONT, 8'h00, 2'b11, D0); cycle(); check("R12 beat", 1'b0, '0);
        apply(V_CONT, 8'h00, 2'b11, D1); cycle(); check("R12 beat", 1'b0, '0);
        apply(V_CONT, 8'h00, 2'b11, D2); cycle(); check("R12 beat", 1'b0, '0);
        apply(V_DES, 8'h00, 2'b11, D3);  cycle(); check("R6 deselect after burst", 1'b0, '0);

        // R9 linear read from 0x43 with wrap
        apply(V_RD, 8'h43, 2'b00, '0);  cycle(); check("R9 R12 beat0", 1'b1, D1);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R9 R12 beat1", 1'b1, D2);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R9 R12 beat2", 1'b1, D3);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R9 R12 beat3", 1'b1, D0);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R9 wrap", 1'b1, D1);

        // R10 interleaved read from 0x41: 41,40,43,42
        burst_ilv = 1'b1;
        apply(V_RD, 8'h41, 2'b00, '0);  cycle(); check("R10 beat0", 1'b1, D3);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R10 beat1", 1'b1, D2);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R10 beat2", 1'b1, D1);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R10 beat3", 1'b1, D0);
        burst_ilv = 1'b0;

        // R5 stall holds output and burst position
        apply(V_RD, 8'h40, 2'b00, '0);  cycle(); check("R5 pre-stall", 1'b1, D2);
        apply(V_RD, 8'h42, 2'b00, '0);  clk_en = 1'b0;
        cycle(); check("R5 output held", 1'b1, D2);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R5 burst resumes", 1'b1, D3);

        // R5 stall between write address and data: stalled wdata ignored
        apply(V_WR, 8'h50, 2'b11, '0);  cycle(); check("R8 write addr", 1'b0, '0);
        apply(V_RD, 8'h60, 2'b11, 18'h11111); clk_en = 1'b0;
        cycle(); check("R5 R8 stalled data phase", 1'b0, '0);
        apply(V_RD, 8'h50, 2'b11, 18'h22222); cycle(); check("R5 R4 forward", 1'b1, 18'h22222);
        apply(V_RD, 8'h50, 2'b11, '0);  cycle(); check("R5 committed", 1'b1, 18'h22222);

        // R6 each chip enable alone deselects
        for (int k = 0; k < 3; k++) begin
            apply(V_RD, 8'h42, 2'b00, '0);
            {ce_a, ce_b, ce_c} = 3'b111 & ~(3'b100 >> k);
            cycle(); check($sformatf("R6 enable %0d low", k), 1'b0, '0);
        end
        apply(V_WR, 8'h42, 2'b11, '0); ce_b = 1'b0;
        cycle(); check("R6 deselected write", 1'b0, '0);
        apply(V_RD, 8'h42, 2'b00, 18'h3FFFF); cycle(); check("R6 word unchanged", 1'b1, D0);
        apply(V_RD, 8'h42, 2'b00, '0);  cycle(); check("R6 word unchanged again", 1'b1, D0);

        // R11 continue while deselected
        apply(V_DES, 8'h00, 2'b00, '0); cycle(); check("R11 deselect", 1'b0, '0);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R11 continue", 1'b0, '0);
        apply(V_CONT, 8'h00, 2'b00, '0); cycle(); check("R11 continue", 1'b0, '0);

        // R7 asynchronous output enable
        apply(V_RD, 8'h42, 2'b00, '0);  cycle(); check("R7 before", 1'b1, D0);
        clk_en = 1'b0;
        oe = 1'b0; #1 check("R7 oe low", 1'b0, '0);
        oe = 1'b1; #1 check("R7 oe restored", 1'b1, D0);
        clk_en = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule